// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a pipelined synchronous burst memory. On every rising clock edge it samples a master enable, two secondary enables (one active high, one active low), two active-low address strobes and an active-low advance input. A strobe that is properly qualified loads a new word address. A strobe that arrives while the enables are not all active sends the block into standby. With no strobe present, a low advance moves a 2-bit beat counter on to the next word of a four-word burst.

The two strobes differ in how they are qualified. The controller strobe is always sampled. The processor strobe only counts when the master enable is active; otherwise it is ignored completely. A static order pin picks the burst order. When it is high, the low address bits are the starting bits XORed with the beat count (interleaved). When it is low, the low bits step upward modulo 4 (linear). The pin should be tied high when interleaved order is wanted. The outputs are the current word address, a selected flag and a standby flag.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, word_addr is 0, selected is 0 and standby is 1. At every clock, exactly one of selected and standby is 1.
- R2: A low strb_ctrl_n with all enables active (ce_master_n=0, ce_hi=1, ce_lo_n=0) loads addr_in. In the next cycle word_addr equals addr_in, selected=1 and standby=0.
- R3: When ce_master_n=1, strb_proc_n has no effect. The cycle behaves exactly as if strb_proc_n were high: it holds, or it advances if adv_n is low.
- R4: A low strb_proc_n with ce_master_n=0 loads addr_in if ce_hi=1 and ce_lo_n=0. If either secondary enable is inactive, it deselects instead.
- R5: A qualified strobe (R2/R4 conditions) with any enable inactive deselects: the next cycle has selected=0 and standby=1, and word_addr is unchanged.
- R6: With no qualified strobe, adv_n=0 while selected steps the beat count by one in the next cycle.
- R7: With order_xor=1, word_addr[1:0] = start[1:0] XOR beat, where start is the loaded address and beat is the number of advances since the load, modulo 4.
- R8: With order_xor=0, word_addr[1:0] = (start[1:0] + beat) mod 4.
- R9: With no qualified strobe and adv_n high, word_addr, selected and standby hold.
- R10: After four advances the address returns to the loaded value. word_addr[15:2] never changes without a load.
- R11: When both strobes are low in the same cycle, the controller strobe's qualification applies, and a single load resets the beat count to 0.
- R12: While in standby, adv_n=0 has no effect on word_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_master_n | input | 1 | Master enable, active low; also gates the processor strobe |
| ce_hi | input | 1 | Secondary enable, active high |
| ce_lo_n | input | 1 | Secondary enable, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | Static burst order: 1 interleaved, 0 linear |
| addr_in | input | 16 | External word address |
| word_addr | output | 16 | Current internal word address |
| selected | output | 1 | Device selected |
| standby | output | 1 | Device in standby |

## Verification
The bench builds the block with its default widths: a 16-bit address and a 2-bit beat counter. With these values a full burst wraps after only four advances, so both orderings can be driven through a complete wrap from several starting offsets within a few cycles. A small address also lets the bench spot any disturbance of the upper bits by comparison. Every combination of strobe and enable that matters (blocked processor strobe, a missing secondary enable, both strobes together) is placed between bursts, and the bench's behavioural model is compared against the outputs on every clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_DESEL = 2'd2,
    OP_ADV   = 2'd3
  } seq_op_e;
endpackage

// File: rtl/bseq_strobe_decode.sv
module bseq_strobe_decode
  import bseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ce_master_n,
  input  logic    ce_hi,
  input  logic    ce_lo_n,
  input  logic    strb_proc_n,
  input  logic    strb_ctrl_n,
  input  logic    adv_n,
  input  logic    selected,
  output seq_op_e op
);
  logic enables_all;
  logic ctrl_seen;
  logic proc_seen;
  logic strobe_hit;

  assign enables_all = !ce_master_n && ce_hi && !ce_lo_n;
  assign ctrl_seen   = !strb_ctrl_n;
  // processor strobe is gated by the master enable
  assign proc_seen   = !strb_proc_n && !ce_master_n;
  // controller strobe wins when both are present; qualification is the same
  assign strobe_hit  = ctrl_seen || proc_seen;

  always_comb begin
    if (strobe_hit)              op = enables_all ? OP_LOAD : OP_DESEL;
    else if (!adv_n && selected) op = OP_ADV;
    else                         op = OP_HOLD;
  end

  // R3: master inactive and no controller strobe -> no load or deselect
  p_proc_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_master_n && strb_ctrl_n) |-> (op != OP_LOAD && op != OP_DESEL));
  // R12: no advance while in standby
  p_no_adv_standby_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> op != OP_ADV);
endmodule

// File: rtl/bseq_burst_ctr.sv
module bseq_burst_ctr
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_xor,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] low_bits;

  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               interleave);
    if (interleave) return start ^ beat;
    else            return start + beat;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          base_q <= addr_in;
          beat_q <= '0;
        end
        OP_ADV:  beat_q <= beat_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign low_bits  = burst_low(base_q[BURST_W-1:0], beat_q, order_xor);
  assign word_addr = {base_q[ADDR_W-1:BURST_W], low_bits};

  // R6: an advance steps the beat by exactly one
  p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ADV |=> beat_q == BURST_W'($past(beat_q) + 1'b1));
  // R10: upper address bits move only on a load
  p_upper_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op != OP_LOAD |=> $stable(word_addr[ADDR_W-1:ADDR_W-UPPER_W]));
  // R11: a load restarts the burst at beat zero
  p_load_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> beat_q == '0);
endmodule

// File: rtl/bseq_sel_state.sv
module bseq_sel_state
  import bseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_op_e op,
  output logic    selected,
  output logic    standby
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected <= 1'b0;
      standby  <= 1'b1;
    end else if (op == OP_LOAD) begin
      selected <= 1'b1;
      standby  <= 1'b0;
    end else if (op == OP_DESEL) begin
      selected <= 1'b0;
      standby  <= 1'b1;
    end
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    selected != standby);
  p_load_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> selected && !standby);
  p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_DESEL |=> !selected && standby);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_master_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              selected,
  output logic              standby
);
  seq_op_e op;

  bseq_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_master_n(ce_master_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .selected(selected), .op(op)
  );

  bseq_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .op(op), .addr_in(addr_in),
    .order_xor(order_xor), .word_addr(word_addr)
  );

  bseq_sel_state u_sel (
    .clk(clk), .rst_n(rst_n), .op(op), .selected(selected), .standby(standby)
  );

  // R9: idle cycles leave the address alone
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD || op == OP_DESEL) |=> $stable(word_addr));
  // R2: load presents the external address
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> word_addr == $past(addr_in));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_master_n = 1'b1, ce_hi = 1'b0, ce_lo_n = 1'b1;
  logic        strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
  logic        order_xor = 1'b1;
  logic [15:0] addr_in = '0;
  logic [15:0] word_addr;
  logic        selected, standby;

  int tests = 0, fails = 0;
  int m_base = 0, m_beat = 0;
  bit m_sel = 0;

  always #4 clk = ~clk;

  burst_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ce_master_n(ce_master_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .order_xor(order_xor), .addr_in(addr_in),
    .word_addr(word_addr), .selected(selected), .standby(standby)
  );

  function automatic int expect_addr();
    int start, low;
    start = m_base % 4;
    if (order_xor) low = start ^ m_beat;
    else           low = (start + m_beat) % 4;
    return (m_base / 4) * 4 + low;
  endfunction

  task automatic check(string tag);
    int ea;
    ea = expect_addr();
    tests++;
    if (int'(word_addr) != ea || selected != m_sel || standby != !m_sel) begin
      fails++;
      $display("FAIL %s: addr=%h sel=%b stby=%b expected addr=%h sel=%b stby=%b",
               tag, word_addr, selected, standby, ea[15:0], m_sel, !m_sel);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare after it
  task automatic step(bit mn, bit hi, bit lon, bit pn, bit cn, bit an,
                      logic [15:0] a, string tag);
    bit all_en;
    @(negedge clk);
    ce_master_n = mn; ce_hi = hi; ce_lo_n = lon;
    strb_proc_n = pn; strb_ctrl_n = cn; adv_n = an; addr_in = a;
    @(posedge clk);
    all_en = !mn && hi && !lon;
    if (!cn || (!pn && !mn)) begin
      if (all_en) begin m_base = int'(a); m_beat = 0; m_sel = 1; end
      else m_sel = 0;
    end else if (!an && m_sel) begin
      m_beat = (m_beat + 1) % 4;
    end
    #2;
    check(tag);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20;
    check("R1 reset");
    rst_n = 1'b1;
    // interleaved burst from offset 1, with wrap
    order_xor = 1'b1;
    step(0,1,0, 1,0,1, 16'hABCD, "R2 ctrl load");
    for (int i = 0; i < 5; i++) step(1,0,1, 1,1,0, 16'h0000, "R7 R10 interleaved adv");
    step(1,0,1, 1,1,1, 16'hFFFF, "R9 hold");
    step(1,0,1, 1,1,1, 16'h1234, "R9 hold");
    // processor strobe blocked by master enable; advance still proceeds
    step(1,1,0, 0,1,0, 16'h5555, "R3 proc blocked adv");
    step(1,1,0, 0,1,1, 16'h5555, "R3 proc blocked hold");
    // controller strobe with a secondary enable off -> standby
    step(0,0,0, 1,0,1, 16'h7777, "R5 ctrl desel hi off");
    step(1,0,1, 1,1,0, 16'h0000, "R12 adv in standby");
    step(0,1,1, 1,0,1, 16'h7777, "R5 ctrl desel lo_n off");
    step(1,1,0, 1,0,1, 16'h7777, "R5 ctrl desel master off");
    // processor load, linear order
    order_xor = 1'b0;
    step(0,1,0, 0,1,1, 16'h1236, "R4 proc load");
    for (int i = 0; i < 5; i++) step(1,0,1, 1,1,0, 16'h0000, "R8 R10 linear adv");
    step(0,0,0, 0,1,1, 16'h4444, "R4 proc desel hi off");
    step(0,1,1, 0,1,1, 16'h4444, "R4 proc desel lo_n off");
    // both strobes
    step(0,1,0, 0,0,1, 16'h0F03, "R11 both load");
    for (int i = 0; i < 3; i++) step(1,0,1, 1,1,0, 16'h0000, "R11 R8 adv after both");
    step(0,1,0, 0,0,1, 16'h0F03, "R11 reload restarts beat");
    step(0,0,0, 0,0,0, 16'h1111, "R11 both desel");
    order_xor = 1'b1;
    step(0,1,0, 1,0,1, 16'h8002, "R2 ctrl load");
    for (int i = 0; i < 4; i++) step(1,0,1, 1,1,0, 16'h0000, "R7 R10 interleaved wrap");
    step(0,1,0, 1,0,0, 16'hC3C1, "R2 strobe beats advance");
    step(1,0,1, 1,1,0, 16'h0000, "R6 advance");
    step(1,0,1, 1,1,0, 16'h0000, "R6 advance");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule